// File: doc/BRIEF.md
# Compressed Immediate-Format Instruction Expander

This front-end stage sits between instruction fetch and a single native 32-bit decoder. Each cycle it may accept one 32-bit fetched word. A lane bit picks which 16-bit half-word holds the next compressed instruction. A mode bit chooses what goes forward: either the fetched word unchanged, or a 32-bit native instruction rebuilt from that half-word. Because of this, the downstream decoder never needs to know about the short encoding.

Only the compressed group that moves, compares, adds or subtracts an 8-bit immediate is rebuilt. It is rebuilt as an always-executed, flag-setting data-processing instruction with an immediate operand. Any other compressed encoding is marked undefined, and a harmless no-op goes forward in its place. The result is registered: it appears one cycle after the input is accepted, qualified by a valid flag.

Top module: `cmp_expander`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `out_undef` and `out_insn` are all zero.
- R2: With `cmp_mode` low, `out_insn` equals the accepted `fetch_word` unchanged and `out_undef` is 0, whatever the state of `lane_hi`.
- R3: With `cmp_mode` high, `lane_hi`=1 takes the compressed half-word from `fetch_word[31:16]`, and `lane_hi`=0 takes it from `fetch_word[15:0]`.
- R4: A half-word belongs to the immediate group when its bits 15:13 are 001. Bits 12:11 select the operation, bits 10:8 name a register 0..7, and bits 7:0 hold the immediate. Every instruction rebuilt from this group has bits 31:28 = 1110, bits 27:26 = 00, bit 25 = 1 and bit 20 = 1. Its bits 11:8 are 0000, and its bits 7:0 carry the immediate, zero-extended.
- R5: Minor code 00 (move) gives opcode 1101 in bits 24:21, with bits 19:16 = 0000 and the register in bits 15:12.
- R6: Minor code 01 (compare) gives opcode 1010, with the register in bits 19:16 and bits 15:12 = 0000.
- R7: Minor code 10 (add) gives opcode 0100, and minor code 11 (subtract) gives opcode 0010. In both cases the register goes into bits 19:16 and into bits 15:12.
- R8: In compressed mode, a half-word whose bits 15:13 are not 001 sets `out_undef`=1 and drives `out_insn` = 32'hE1A00000 (a register-to-itself move, a no-op).
- R9: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. When `in_valid` is low, `out_insn` and `out_undef` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Fetched word and controls are valid this cycle |
| fetch_word | input | 32 | Fetched instruction word |
| lane_hi | input | 1 | 1 selects the upper half-word, 0 the lower |
| cmp_mode | input | 1 | 1 expands the selected half-word, 0 passes the word through |
| out_valid | output | 1 | Registered result is valid |
| out_insn | output | 32 | Native 32-bit instruction |
| out_undef | output | 1 | Selected compressed encoding is outside the supported group |

## Verification
Lane selection and undefined detection can act on the same word in the same cycle. The bench sends words whose two halves differ: one half is a supported immediate instruction and the other is an unsupported encoding. It then toggles `lane_hi` on consecutive accepted cycles. Each result is judged against an expansion computed independently in the bench, so a swapped lane shows up as a wrong undefined flag, or as a rebuilt instruction where a no-op was expected. Mode switches between native and compressed on back-to-back cycles, and idle gaps, are mixed in so that the hold behaviour and the one-cycle latency are judged in the same runs.

// File: rtl/cx_pkg.sv
// Package: shared encodings for the compressed immediate expander.
// Assumes a 32-bit native word and 16-bit compressed half-words.
package cx_pkg;
    localparam int NATIVE_W = 32;
    localparam int HALF_W   = 16;
    localparam int REG_W    = 3;
    localparam int IMM_W    = 8;

    typedef enum logic [1:0] {
        CX_MOV = 2'b00,
        CX_CMP = 2'b01,
        CX_ADD = 2'b10,
        CX_SUB = 2'b11
    } cx_minor_e;

    localparam logic [2:0]  GROUP_TAG = 3'b001;
    localparam logic [3:0]  COND_AL   = 4'b1110;
    localparam logic [3:0]  OPC_MOV   = 4'b1101;
    localparam logic [3:0]  OPC_CMP   = 4'b1010;
    localparam logic [3:0]  OPC_ADD   = 4'b0100;
    localparam logic [3:0]  OPC_SUB   = 4'b0010;
    localparam logic [31:0] NOP_WORD  = 32'hE1A0_0000;

    typedef struct packed {
        logic [NATIVE_W-1:0] insn;
        logic                undef;
    } cx_result_t;
endpackage

// File: rtl/cx_lane_select.sv
// Module: picks one half-word lane out of a fetched word.
// Assumes WORD_W is even; sel_hi=1 returns the upper half.
module cx_lane_select #(
    parameter int WORD_W = 32,
    localparam int LANE_W = WORD_W / 2
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              sel_hi,
    output logic [LANE_W-1:0] lane_out
);
    // Lane multiplexer, one bit per generate iteration.
    for (genvar b = 0; b < LANE_W; b++) begin : g_bit
        assign lane_out[b] = sel_hi ? word_in[b + LANE_W] : word_in[b];
    end
endmodule

// File: rtl/cx_imm_expand.sv
// Module: rebuilds one compressed immediate-group half-word as a native
// data-processing instruction. It is purely combinational.
// Assumes the caller qualifies the result with cmp mode; any tag other
// than the group tag yields undef and the no-op word.
module cx_imm_expand
    import cx_pkg::*;
(
    input  logic [HALF_W-1:0] half_in,
    output cx_result_t        res
);
    logic [2:0]       tag;
    cx_minor_e        minor;
    logic [REG_W-1:0] rnum;
    logic [IMM_W-1:0] imm;
    logic [3:0]       opc;
    logic [3:0]       rn_f;
    logic [3:0]       rd_f;

    assign tag   = half_in[15:13];
    assign minor = cx_minor_e'(half_in[12:11]);
    assign rnum  = half_in[10:8];
    assign imm   = half_in[7:0];

    // Opcode and register-field routing per minor code.
    always_comb begin
        opc  = OPC_ADD;
        rn_f = {1'b0, rnum};
        rd_f = {1'b0, rnum};
        unique case (minor)
            CX_MOV: begin opc = OPC_MOV; rn_f = 4'd0; end
            CX_CMP: begin opc = OPC_CMP; rd_f = 4'd0; end
            CX_ADD: opc = OPC_ADD;
            CX_SUB: opc = OPC_SUB;
            default: opc = OPC_ADD;
        endcase
    end

    // Assemble the native word, or substitute the no-op for foreign tags.
    always_comb begin
        if (tag == GROUP_TAG) begin
            res.insn  = {COND_AL, 2'b00, 1'b1, opc, 1'b1, rn_f, rd_f, 4'b0000, imm};
            res.undef = 1'b0;
        end else begin
            res.insn  = NOP_WORD;
            res.undef = 1'b1;
        end
    end
endmodule

// File: rtl/cmp_expander.sv
// Module: top of the expander stage. It selects a lane, expands it or
// passes the native word through, and registers the result with one
// cycle of latency. Assumes a synchronous active-low reset.
module cmp_expander
    import cx_pkg::*;
#(
    parameter int WORD_W = NATIVE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic              lane_hi,
    input  logic              cmp_mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_insn,
    output logic              out_undef
);
    localparam int LANE_W = WORD_W / 2;

    logic [LANE_W-1:0] lane;
    cx_result_t        exp_res;
    logic [WORD_W-1:0] nxt_insn;
    logic              nxt_undef;

    cx_lane_select #(.WORD_W(WORD_W)) u_lane (
        .word_in (fetch_word),
        .sel_hi  (lane_hi),
        .lane_out(lane)
    );

    cx_imm_expand u_exp (
        .half_in(lane),
        .res    (exp_res)
    );

    // Stream multiplexer: native word or expanded instruction.
    always_comb begin
        if (cmp_mode) begin
            nxt_insn  = exp_res.insn;
            nxt_undef = exp_res.undef;
        end else begin
            nxt_insn  = fetch_word;
            nxt_undef = 1'b0;
        end
    end

    // Output register: valid follows input valid, data loads only when valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_insn  <= '0;
            out_undef <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_insn  <= nxt_insn;
                out_undef <= nxt_undef;
            end
        end
    end

    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_insn) && $stable(out_undef)));
    assert_native_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cmp_mode) |=> (!out_undef && out_insn == $past(fetch_word)));
    assert_undef_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> (out_insn == NOP_WORD));
    assert_fixed_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cmp_mode && lane[15:13] == GROUP_TAG) |=>
        (out_insn[31:25] == 7'b1110001 && out_insn[20] && out_insn[11:8] == 4'b0000));
endmodule

// File: tb/sim_cmp_expander.sv
module sim_cmp_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] fetch_word = '0;
    logic        lane_hi = 1'b0;
    logic        cmp_mode = 1'b0;
    logic        out_valid;
    logic [31:0] out_insn;
    logic        out_undef;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [32:0] exp_q[$];
    logic [31:0] last_insn = '0;
    logic        last_undef = 1'b0;

    always #10 clk = ~clk;

    cmp_expander u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fetch_word(fetch_word),
        .lane_hi(lane_hi), .cmp_mode(cmp_mode), .out_valid(out_valid),
        .out_insn(out_insn), .out_undef(out_undef)
    );

    // Bench-side model of the expansion rules (R4..R8).
    function automatic logic [32:0] model(input logic [31:0] w, input logic hi, input logic cm);
        logic [15:0] h;
        logic [3:0] op, rn, rd;
        if (!cm) return {1'b0, w};
        h = hi ? w[31:16] : w[15:0];
        if (h[15:13] != 3'b001) return {1'b1, 32'hE1A00000};
        rn = {1'b0, h[10:8]};
        rd = {1'b0, h[10:8]};
        case (h[12:11])
            2'b00: begin op = 4'b1101; rn = 4'd0; end
            2'b01: begin op = 4'b1010; rd = 4'd0; end
            2'b10: op = 4'b0100;
            default: op = 4'b0010;
        endcase
        return {1'b0, 4'b1110, 3'b001, op, 1'b1, rn, rd, 4'b0000, h[7:0]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one accepted word, expectation pushed to the scoreboard.
    task automatic send(input logic [31:0] w, input logic hi, input logic cm);
        @(negedge clk);
        in_valid = 1'b1; fetch_word = w; lane_hi = hi; cmp_mode = cm;
        exp_q.push_back(model(w, hi, cm));
        @(negedge clk);
        in_valid = 1'b0; fetch_word = ~w; lane_hi = ~hi; cmp_mode = ~cm;
    endtask

    task automatic send_b2b(input logic [31:0] w, input logic hi, input logic cm);
        @(negedge clk);
        in_valid = 1'b1; fetch_word = w; lane_hi = hi; cmp_mode = cm;
        exp_q.push_back(model(w, hi, cm));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; fetch_word = $urandom; lane_hi = i[0]; cmp_mode = ~i[0];
        end
    endtask

    // Monitor: pops expectations for valid outputs, checks hold otherwise (R9).
    initial begin
        forever begin
            @(posedge clk); #2;
            if (rst_n && !done) begin
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9 unexpected valid", {out_undef, out_insn}, 33'h0);
                    end else begin
                        logic [32:0] e;
                        e = exp_q.pop_front();
                        // R2..R8 judged against the model
                        check({out_undef, out_insn} === e, "R2-R8 result", {out_undef, out_insn}, e);
                    end
                end else begin
                    check({out_undef, out_insn} === {last_undef, last_insn}, "R9 hold",
                          {out_undef, out_insn}, {last_undef, last_insn});
                end
                last_insn = out_insn; last_undef = out_undef;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({out_valid, out_undef, out_insn} === 34'h0, "R1 in reset", {out_undef, out_insn}, 33'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check({out_valid, out_undef, out_insn} === 34'h0, "R1 after reset", {out_undef, out_insn}, 33'h0);
        // R2 native pass-through, both lanes
        send(32'h1234_5678, 1'b0, 1'b0);
        send(32'h2000_00FF, 1'b1, 1'b0);
        // R5 move, R6 compare, R7 add/sub in the low lane
        send(32'hFFFF_2142, 1'b0, 1'b1);
        send(32'h0000_2FFF, 1'b0, 1'b1);
        send(32'h0000_335A, 1'b0, 1'b1);
        send(32'h0000_3F80, 1'b0, 1'b1);
        // R3 upper lane, R4 zero-extended immediate
        send(32'h3C81_0000, 1'b1, 1'b1);
        send(32'h2F00_2A01, 1'b1, 1'b1);
        // R8 undefined tags
        send(32'h0000_4123, 1'b0, 1'b1);
        send(32'hE000_0000, 1'b1, 1'b1);
        // R3 with R8: one valid half, one foreign half, lanes toggled back to back
        send_b2b(32'h2A55_8001, 1'b1, 1'b1);
        send_b2b(32'h2A55_8001, 1'b0, 1'b1);
        send_b2b(32'hC003_3B7E, 1'b0, 1'b1);
        send_b2b(32'hC003_3B7E, 1'b1, 1'b1);
        send_b2b(32'hC003_3B7E, 1'b1, 1'b0);
        idle(3);
        // R9 long mixed stream
        for (int i = 0; i < 200; i++) begin
            if (i % 7 == 3) idle(1 + i % 3);
            send_b2b({$urandom} | ((i % 2) ? 32'h2000_2000 : 32'h0), i[1], i % 5 != 0);
        end
        idle(4);
        check(exp_q.size() == 0, "R9 all results delivered", 33'(exp_q.size()), 33'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule